// File: doc/BRIEF.md
# Sampling Core-Switch Controller

This controller decides, at run time and without any foreknowledge, which core of a set of cores that share one instruction set should run a single program. The cores are numbered along a continuum from the smallest and least power-hungry (core 0) to the largest and most capable (core N-1). The controller watches a stream of interval-end strobes. Each strobe carries the energy spent and the cycles taken during the interval that just finished. From time to time it moves execution onto one or more candidate cores for a short trial. It compares their measured energy-delay with that of the core it started from, and then settles on the cheapest one.

Migrations are requested from an external sequencer through a one-cycle request carrying the target core. The sequencer answers with a done pulse once execution runs on the target. Energy-delay for a window is the sum of energies times the sum of cycles over a fixed number of intervals. Every window has the same length, so the products compare directly and no division is needed. The measurement hardware and the migration mechanism sit outside this block.

Top module: `core_switch_sampler`

## Requirements
- R1: After reset, cur_core equals the START_CORE parameter (default 0) and sw_req is low.
- R2: In normal running, a sampling episode starts at the PERIOD-th interval strobe (default 100). sw_req rises in the cycle after that strobe is sampled, and never earlier.
- R3: Each trial on a candidate lasts SAMPLE_LEN intervals (default 5). The first WARMUP intervals (default 1) are discarded and the rest form the measured window. The baseline window is the last SAMPLE_LEN-WARMUP intervals before the episode starts.
- R4: mode 0 (neighbour) picks one core adjacent to the home core: the lower one when the random value is even, the higher one when it is odd. Core 0 always picks core 1 and core N-1 always picks core N-2. mode 1 picks its candidate by the same rule.
- R5: In modes 0 and 2 the candidate is kept only if its window energy-delay is strictly below the baseline, which costs one migration. Otherwise a second request sends execution back to the home core.
- R6: In mode 1 (cumulative) the candidate wins when (TE+Ec)*(TC+Cc) < (TE+Eb)*(TC+Cb). TE and TC are the energy and cycle totals of every baseline window since reset, the current one included. Ec and Cc are the candidate window sums, and Eb and Cb are the baseline sums.
- R7: mode 2 (random) takes k = rnd mod (N-1) and samples core k when k is below the home core, otherwise core k+1.
- R8: mode 3 (exhaustive) samples every core except the home core in ascending order and commits to the lowest energy-delay seen, the baseline included. On a tie the earlier entry stays. A final request is issued only when the winner is not the core last sampled.
- R9: While a migration is pending, no new request is issued and interval strobes are ignored. Counting resumes only after mig_done.
- R10: The random value comes from a 16-bit shift register, seeded with LFSR_SEED (default 0xACE1). It shifts left once at the start of each episode, with feedback bit0 = b15^b13^b12^b10, and the value after the shift is the one used.
- R11: The mode is captured at the start of an episode. Changes on the mode input during the episode have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Candidate policy: 0 neighbour, 1 cumulative neighbour, 2 random, 3 exhaustive |
| ivl_end | input | 1 | One-cycle strobe marking the end of an interval |
| ivl_energy | input | E_W | Energy of the finished interval |
| ivl_cycles | input | C_W | Cycles of the finished interval |
| mig_done | input | 1 | Sequencer reports the requested migration complete |
| sw_req | output | 1 | One-cycle migration request |
| sw_target | output | CW | Core to migrate to, valid with sw_req |
| cur_core | output | CW | Core currently executing |

## Verification
Every trial opens with a very costly warm-up interval, so a design that measured it would reverse its decisions. One neighbour trial is cheaper and is kept. Another has exactly the baseline energy-delay and must return home, which separates a strict compare from a non-strict one. A cumulative-mode trial is built to win on its own window but lose on the running totals, and an exhaustive sweep with graded costs exposes the candidate order and the final commit. A stalled migration receives stray strobes and a mode change, which shows whether the window is counted only after mig_done and whether the captured policy holds.

// File: rtl/csw_pkg.sv
package csw_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_MIG  = 2'd1,
    ST_SAMP = 2'd2
  } csw_state_e;

  typedef enum logic [1:0] {
    MD_NEIGH  = 2'd0,
    MD_GLOBAL = 2'd1,
    MD_RAND   = 2'd2,
    MD_ALL    = 2'd3
  } csw_mode_e;

  function automatic logic [15:0] lfsr16_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/csw_lfsr.sv
module csw_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] nxt
);
  import csw_pkg::*;

  logic [15:0] state_q, state_d;

  always_comb begin
    nxt     = lfsr16_step(state_q);
    state_d = step ? nxt : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R10: a nonzero seed never reaches the all-zero lock-up state
  a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 16'h0000);

endmodule

// File: rtl/csw_win_acc.sv
module csw_win_acc #(
  parameter int E_W  = 16,
  parameter int C_W  = 16,
  parameter int SE_W = 19,
  parameter int SC_W = 19,
  localparam int ED_W = SE_W + SC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            add_en,
  input  logic            clr,
  input  logic [E_W-1:0]  e_in,
  input  logic [C_W-1:0]  c_in,
  output logic [SE_W-1:0] e_nx,
  output logic [SC_W-1:0] c_nx,
  output logic [ED_W-1:0] ed_nx
);
  logic [SE_W-1:0] e_sum_q, e_sum_d;
  logic [SC_W-1:0] c_sum_q, c_sum_d;

  always_comb begin
    e_nx  = e_sum_q + SE_W'(e_in);
    c_nx  = c_sum_q + SC_W'(c_in);
    ed_nx = ED_W'(e_nx) * ED_W'(c_nx);
    if (clr) begin
      e_sum_d = '0;
      c_sum_d = '0;
    end else if (add_en) begin
      e_sum_d = e_nx;
      c_sum_d = c_nx;
    end else begin
      e_sum_d = e_sum_q;
      c_sum_d = c_sum_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_sum_q <= '0;
      c_sum_q <= '0;
    end else begin
      e_sum_q <= e_sum_d;
      c_sum_q <= c_sum_d;
    end
  end

endmodule

// File: rtl/csw_cand_pick.sv
module csw_cand_pick #(
  parameter int N_CORES = 4,
  parameter int CW      = 2
) (
  input  csw_pkg::csw_mode_e mode_i,
  input  logic [CW-1:0]      home_i,
  input  logic [15:0]        rnd_i,
  input  logic [CW-1:0]      prev_i,
  output logic [CW-1:0]      first_o,
  output logic [CW-1:0]      next_o,
  output logic               next_vld_o
);
  import csw_pkg::*;

  logic [15:0]   k16;
  logic [CW-1:0] kc;
  logic [CW-1:0] lowest_other;

  always_comb begin
    k16 = rnd_i % 16'(N_CORES - 1);
    kc  = CW'(k16);

    lowest_other = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (CW'(i) != home_i) lowest_other = CW'(i);
    end

    next_o     = '0;
    next_vld_o = 1'b0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (i > int'(prev_i) && CW'(i) != home_i) begin
        next_o     = CW'(i);
        next_vld_o = 1'b1;
      end
    end

    case (mode_i)
      MD_NEIGH, MD_GLOBAL: begin
        if (home_i == '0)                      first_o = CW'(1);
        else if (home_i == CW'(N_CORES - 1))   first_o = CW'(N_CORES - 2);
        else if (rnd_i[0])                     first_o = home_i + CW'(1);
        else                                   first_o = home_i - CW'(1);
      end
      MD_RAND:  first_o = (kc < home_i) ? kc : kc + CW'(1);
      default:  first_o = lowest_other;
    endcase
  end

endmodule

// File: rtl/core_switch_sampler.sv
module core_switch_sampler #(
  parameter int          N_CORES    = 4,
  parameter int          START_CORE = 0,
  parameter int          PERIOD     = 100,
  parameter int          SAMPLE_LEN = 5,
  parameter int          WARMUP     = 1,
  parameter int          E_W        = 16,
  parameter int          C_W        = 16,
  parameter int          TOT_W      = 32,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  localparam int         CW         = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic           ivl_end,
  input  logic [E_W-1:0] ivl_energy,
  input  logic [C_W-1:0] ivl_cycles,
  input  logic           mig_done,
  output logic           sw_req,
  output logic [CW-1:0]  sw_target,
  output logic [CW-1:0]  cur_core
);
  import csw_pkg::*;

  localparam int MEAS  = SAMPLE_LEN - WARMUP;
  localparam int GROW  = $clog2(MEAS + 1);
  localparam int SE_W  = E_W + GROW;
  localparam int SC_W  = C_W + GROW;
  localparam int ED_W  = SE_W + SC_W;
  localparam int RC_W  = $clog2(PERIOD);
  localparam int SM_W  = (SAMPLE_LEN > 1) ? $clog2(SAMPLE_LEN) : 1;
  localparam int GT_W  = TOT_W + 1;
  localparam int GP_W  = 2 * GT_W;

  // ---------------- state ----------------
  csw_state_e     state_q, state_d;
  csw_mode_e      mode_q, mode_d;
  logic [RC_W-1:0] run_cnt_q, run_cnt_d;
  logic [SM_W-1:0] smp_cnt_q, smp_cnt_d;
  logic [CW-1:0]  cur_q, cur_d;
  logic [CW-1:0]  home_q, home_d;
  logic [CW-1:0]  cand_q, cand_d;
  logic [CW-1:0]  best_q, best_d;
  logic [ED_W-1:0] best_ed_q, best_ed_d;
  logic [SE_W-1:0] base_e_q, base_e_d;
  logic [SC_W-1:0] base_c_q, base_c_d;
  logic [TOT_W-1:0] tot_e_q, tot_e_d;
  logic [TOT_W-1:0] tot_c_q, tot_c_d;
  logic           after_samp_q, after_samp_d;
  logic           req_q, req_d;
  logic [CW-1:0]  tgt_q, tgt_d;

  // ---------------- helpers ----------------
  logic            acc_add, acc_clr, lfsr_step;
  logic [SE_W-1:0] e_nx;
  logic [SC_W-1:0] c_nx;
  logic [ED_W-1:0] ed_nx;
  logic [15:0]     rnd;
  logic [CW-1:0]   first_cand, next_cand, pick_home;
  logic            next_vld;
  csw_mode_e       mode_in;

  assign mode_in   = csw_mode_e'(mode);
  assign pick_home = (state_q == ST_RUN) ? cur_q : home_q;

  csw_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (lfsr_step),
    .nxt  (rnd)
  );

  csw_win_acc #(.E_W(E_W), .C_W(C_W), .SE_W(SE_W), .SC_W(SC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .add_en(acc_add),
    .clr   (acc_clr),
    .e_in  (ivl_energy),
    .c_in  (ivl_cycles),
    .e_nx  (e_nx),
    .c_nx  (c_nx),
    .ed_nx (ed_nx)
  );

  csw_cand_pick #(.N_CORES(N_CORES), .CW(CW)) u_pick (
    .mode_i    (mode_in),
    .home_i    (pick_home),
    .rnd_i     (rnd),
    .prev_i    (cand_q),
    .first_o   (first_cand),
    .next_o    (next_cand),
    .next_vld_o(next_vld)
  );

  // cumulative comparison and saturating totals
  logic [GT_W-1:0] g_ce, g_cc, g_be, g_bc, tsum_e, tsum_c;
  logic [GP_W-1:0] g_cand, g_base;
  logic            glob_lt, win;
  logic [CW-1:0]   win_core;
  logic [ED_W-1:0] win_ed;

  always_comb begin
    g_ce    = GT_W'(tot_e_q) + GT_W'(e_nx);
    g_cc    = GT_W'(tot_c_q) + GT_W'(c_nx);
    g_be    = GT_W'(tot_e_q) + GT_W'(base_e_q);
    g_bc    = GT_W'(tot_c_q) + GT_W'(base_c_q);
    g_cand  = GP_W'(g_ce) * GP_W'(g_cc);
    g_base  = GP_W'(g_be) * GP_W'(g_bc);
    glob_lt = g_cand < g_base;
    win      = (mode_q == MD_GLOBAL) ? glob_lt : (ed_nx < best_ed_q);
    win_core = win ? cand_q : best_q;
    win_ed   = win ? ed_nx  : best_ed_q;
    tsum_e  = GT_W'(tot_e_q) + GT_W'(e_nx);
    tsum_c  = GT_W'(tot_c_q) + GT_W'(c_nx);
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d      = state_q;
    mode_d       = mode_q;
    run_cnt_d    = run_cnt_q;
    smp_cnt_d    = smp_cnt_q;
    cur_d        = cur_q;
    home_d       = home_q;
    cand_d       = cand_q;
    best_d       = best_q;
    best_ed_d    = best_ed_q;
    base_e_d     = base_e_q;
    base_c_d     = base_c_q;
    tot_e_d      = tot_e_q;
    tot_c_d      = tot_c_q;
    after_samp_d = after_samp_q;
    req_d        = 1'b0;
    tgt_d        = tgt_q;
    acc_add      = 1'b0;
    acc_clr      = 1'b0;
    lfsr_step    = 1'b0;

    case (state_q)
      ST_RUN: begin
        if (ivl_end) begin
          acc_add = (run_cnt_q >= RC_W'(PERIOD - MEAS));
          if (run_cnt_q == RC_W'(PERIOD - 1)) begin
            acc_clr      = 1'b1;
            lfsr_step    = 1'b1;
            run_cnt_d    = '0;
            base_e_d     = e_nx;
            base_c_d     = c_nx;
            best_ed_d    = ed_nx;
            best_d       = cur_q;
            home_d       = cur_q;
            mode_d       = mode_in;
            tot_e_d      = tsum_e[TOT_W] ? '1 : tsum_e[TOT_W-1:0];
            tot_c_d      = tsum_c[TOT_W] ? '1 : tsum_c[TOT_W-1:0];
            cand_d       = first_cand;
            req_d        = 1'b1;
            tgt_d        = first_cand;
            after_samp_d = 1'b1;
            state_d      = ST_MIG;
          end else begin
            run_cnt_d = run_cnt_q + RC_W'(1);
          end
        end
      end

      ST_MIG: begin
        if (mig_done) begin
          cur_d     = tgt_q;
          smp_cnt_d = '0;
          run_cnt_d = '0;
          state_d   = after_samp_q ? ST_SAMP : ST_RUN;
        end
      end

      ST_SAMP: begin
        if (ivl_end) begin
          acc_add = (smp_cnt_q >= SM_W'(WARMUP));
          if (smp_cnt_q == SM_W'(SAMPLE_LEN - 1)) begin
            acc_clr   = 1'b1;
            smp_cnt_d = '0;
            best_d    = win_core;
            best_ed_d = win_ed;
            if (mode_q == MD_ALL && next_vld) begin
              cand_d       = next_cand;
              req_d        = 1'b1;
              tgt_d        = next_cand;
              after_samp_d = 1'b1;
              state_d      = ST_MIG;
            end else if (win_core == cand_q) begin
              run_cnt_d = '0;
              state_d   = ST_RUN;
            end else begin
              req_d        = 1'b1;
              tgt_d        = win_core;
              after_samp_d = 1'b0;
              state_d      = ST_MIG;
            end
          end else begin
            smp_cnt_d = smp_cnt_q + SM_W'(1);
          end
        end
      end

      default: state_d = ST_RUN;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      mode_q       <= MD_NEIGH;
      run_cnt_q    <= '0;
      smp_cnt_q    <= '0;
      cur_q        <= CW'(START_CORE);
      home_q       <= CW'(START_CORE);
      cand_q       <= '0;
      best_q       <= '0;
      best_ed_q    <= '0;
      base_e_q     <= '0;
      base_c_q     <= '0;
      tot_e_q      <= '0;
      tot_c_q      <= '0;
      after_samp_q <= 1'b0;
      req_q        <= 1'b0;
      tgt_q        <= CW'(START_CORE);
    end else begin
      state_q      <= state_d;
      mode_q       <= mode_d;
      run_cnt_q    <= run_cnt_d;
      smp_cnt_q    <= smp_cnt_d;
      cur_q        <= cur_d;
      home_q       <= home_d;
      cand_q       <= cand_d;
      best_q       <= best_d;
      best_ed_q    <= best_ed_d;
      base_e_q     <= base_e_d;
      base_c_q     <= base_c_d;
      tot_e_q      <= tot_e_d;
      tot_c_q      <= tot_c_d;
      after_samp_q <= after_samp_d;
      req_q        <= req_d;
      tgt_q        <= tgt_d;
    end
  end

  assign sw_req    = req_q;
  assign sw_target = tgt_q;
  assign cur_core  = cur_q;

  // ---------------- assertions ----------------
  // R2: every request answers an interval strobe seen on the previous edge
  a_r2_req_after_interval: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> $past(ivl_end));

  // R9: nothing is requested while a migration is still outstanding
  a_r9_quiet_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MIG && !mig_done) |=> !sw_req);

  // R5: a request never targets the core already executing
  a_r5_target_differs: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> (sw_target != cur_core));

  // R4: neighbour policies start on an adjacent core
  a_r4_neighbour_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && after_samp_q && $past(state_q) == ST_RUN &&
     (mode_q == MD_NEIGH || mode_q == MD_GLOBAL))
    |-> (int'(sw_target) == int'(home_q) + 1 || int'(sw_target) + 1 == int'(home_q)));

  // R8: the exhaustive sweep moves upward through the cores
  a_r8_all_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && after_samp_q && $past(state_q) == ST_SAMP)
    |-> (sw_target > $past(cand_q)));

endmodule

// File: tb/core_switch_sampler_tb.sv
module core_switch_sampler_tb;

  localparam int N      = 4;
  localparam int PERIOD = 100;
  localparam int MEASN  = 4;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic        ivl_end;
  logic [15:0] ivl_energy;
  logic [15:0] ivl_cycles;
  logic        mig_done;
  logic        sw_req;
  logic [1:0]  sw_target;
  logic [1:0]  cur_core;

  core_switch_sampler u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ivl_end   (ivl_end),
    .ivl_energy(ivl_energy),
    .ivl_cycles(ivl_cycles),
    .mig_done  (mig_done),
    .sw_req    (sw_req),
    .sw_target (sw_target),
    .cur_core  (cur_core)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int req_cnt = 0;
  int log_t [32];
  bit pending = 0;
  bit auto_done = 1;
  int wait_cd = 0;

  // model state
  int          cur_m = 0;
  logic [15:0] lfsr_m = 16'hACE1;
  longint      te = 0, tc = 0;

  function automatic logic [15:0] step16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // migration sequencer model and request logger
  initial begin
    mig_done = 1'b0;
    forever begin
      @(negedge clk);
      if (mig_done) mig_done = 1'b0;
      if (sw_req) begin
        log_t[req_cnt % 32] = int'(sw_target);
        req_cnt++;
        pending = 1;
        wait_cd = 2;
      end else if (pending && auto_done) begin
        if (wait_cd > 0) wait_cd--;
        else begin
          mig_done = 1'b1;
          pending  = 0;
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic send_ivl(input int e, input int c);
    tick();
    ivl_end = 1'b1; ivl_energy = 16'(e); ivl_cycles = 16'(c);
    tick();
    ivl_end = 1'b0;
  endtask

  task automatic wait_idle();
    do tick(); while (pending || mig_done);
    tick();
  endtask

  task automatic run_period(input int be, input int bc, input int base0);
    repeat (PERIOD - 1) send_ivl(be, bc);
    chk(req_cnt == base0, "R2", "no request before period end", req_cnt, base0);
    send_ivl(be, bc);
    te += MEASN * be;
    tc += MEASN * bc;
  endtask

  // generic episode: model picks candidates and decision
  task automatic episode(input int md, input int be, input int bc,
                         input int ce [4], input int cc [4], input string rq);
    int h, nc, best, last, base0, k;
    int cands [4];
    longint eb, cb, bed, ec, cyc, ed;
    bit w;
    h = cur_m;
    lfsr_m = step16(lfsr_m);
    nc = 0;
    if (md == 0 || md == 1) begin
      if (h == 0) cands[0] = 1;
      else if (h == N - 1) cands[0] = N - 2;
      else cands[0] = lfsr_m[0] ? h + 1 : h - 1;
      nc = 1;
    end else if (md == 2) begin
      k = int'(lfsr_m % 16'(N - 1));
      cands[0] = (k < h) ? k : k + 1;
      nc = 1;
    end else begin
      for (int i = 0; i < N; i++) if (i != h) begin cands[nc] = i; nc++; end
    end
    mode = 2'(md);
    base0 = req_cnt;
    run_period(be, bc, base0);
    eb = MEASN * be; cb = MEASN * bc; bed = eb * cb;
    best = h;
    for (int i = 0; i < nc; i++) begin
      chk(req_cnt == base0 + 1 + i, rq, "request count at candidate", req_cnt, base0 + 1 + i);
      chk(log_t[(base0 + i) % 32] == cands[i], rq, "candidate target",
          log_t[(base0 + i) % 32], cands[i]);
      wait_idle();
      send_ivl(60000, 60000);   // warm-up, must be discarded (R3)
      repeat (MEASN) send_ivl(ce[cands[i]], cc[cands[i]]);
      ec = MEASN * ce[cands[i]]; cyc = MEASN * cc[cands[i]]; ed = ec * cyc;
      if (md == 1) w = ((te + ec) * (tc + cyc)) < ((te + eb) * (tc + cb));
      else         w = ed < bed;
      if (w) begin best = cands[i]; bed = ed; end
    end
    last = cands[nc - 1];
    if (best != last) begin
      chk(req_cnt == base0 + nc + 1, rq, "final request issued", req_cnt, base0 + nc + 1);
      chk(log_t[(base0 + nc) % 32] == best, rq, "final target",
          log_t[(base0 + nc) % 32], best);
      wait_idle();
    end else begin
      tick(); tick();
      chk(req_cnt == base0 + nc, rq, "no extra migration", req_cnt, base0 + nc);
    end
    chk(int'(cur_core) == best, rq, "committed core", cur_core, best);
    cur_m = best;
  endtask

  // R9 / R11: stray strobes during a stalled migration and a mode change
  task automatic test_suppress();
    int h, cand, base0;
    h = cur_m;
    lfsr_m = step16(lfsr_m);
    if (h == 0) cand = 1;
    else if (h == N - 1) cand = N - 2;
    else cand = lfsr_m[0] ? h + 1 : h - 1;
    mode = 2'd0;
    base0 = req_cnt;
    auto_done = 0;
    run_period(10, 10, base0);
    chk(req_cnt == base0 + 1, "R9", "sampling request", req_cnt, base0 + 1);
    chk(log_t[base0 % 32] == cand, "R4", "neighbour target", log_t[base0 % 32], cand);
    mode = 2'd3;   // R11: must not turn this episode into a sweep
    repeat (10) send_ivl(1, 1);
    chk(req_cnt == base0 + 1, "R9", "no request while pending", req_cnt, base0 + 1);
    chk(int'(cur_core) == h, "R9", "core unchanged while pending", cur_core, h);
    auto_done = 1;
    wait_idle();
    chk(int'(cur_core) == cand, "R9", "core after done", cur_core, cand);
    send_ivl(60000, 60000);
    repeat (3) send_ivl(20, 20);
    tick();
    chk(req_cnt == base0 + 1, "R9", "window counts only after done", req_cnt, base0 + 1);
    send_ivl(20, 20);
    chk(req_cnt == base0 + 2, "R5", "return request after loss", req_cnt, base0 + 2);
    chk(log_t[(base0 + 1) % 32] == h, "R11", "return to home, no sweep",
        log_t[(base0 + 1) % 32], h);
    wait_idle();
    tick(); tick();
    chk(req_cnt == base0 + 2, "R11", "two migrations only", req_cnt, base0 + 2);
    chk(int'(cur_core) == h, "R5", "home core restored", cur_core, h);
    cur_m = h;
  endtask

  task automatic test_reset();
    tick();
    chk(cur_core == 2'd0, "R1", "cur_core after reset", cur_core, 0);
    chk(sw_req == 1'b0, "R1", "sw_req after reset", sw_req, 0);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'd0; ivl_end = 1'b0; ivl_energy = '0; ivl_cycles = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    // R3 R4 R5: neighbour from core 0 wins despite a costly warm-up interval
    episode(0, 10, 10, '{5, 5, 5, 5}, '{10, 10, 10, 10}, "R3");
    // R5 R10: equal energy-delay is not a win, execution returns home
    episode(0, 5, 10, '{10, 10, 10, 10}, '{5, 5, 5, 5}, "R10");
    // R7: random candidate, cheaper
    episode(2, 10, 10, '{2, 2, 2, 2}, '{2, 2, 2, 2}, "R7");
    test_suppress();
    // R8: exhaustive sweep, graded costs
    episode(3, 10, 10, '{4, 3, 2, 1}, '{4, 3, 2, 1}, "R8");
    // R6: cumulative mode at the top end, window win but totals lose
    episode(1, 100, 10, '{1, 1, 1, 1}, '{100, 100, 100, 100}, "R6");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule